// File: doc/BRIEF.md
# Fixed-Point Store Issue Formatter

This block sits between the decode stage and the data-memory write port of a 64-bit fixed-point core. Each accepted store arrives as a set of decoded controls: access size, addressing form, an update flag and a byte-reverse flag. With it come the values of the base, index and source registers and the base register number. From these the block works out the effective address. It places the stored field on the correct byte lanes of a 64-bit bus and raises one write request on a single-beat valid/ready port.

In update forms the effective address goes back to the base register through a one-cycle writeback pulse. That pulse fires only once the memory port has taken the write. Encodings that are not legal produce a one-cycle invalid-form flag, with no write and no writeback. An access that would span two 8-byte bus words produces a one-cycle misalign flag, also with no write.

Memory is big-endian: byte lane k of the bus (`mem_wdata[8k+7:8k]`, enable bit k) holds the byte at offset k inside the 8-byte-aligned word. Bit 0 of a register field is its most significant bit.

Top module: `fxst_issue`

## Requirements
- R1: In non-update forms the base operand is zero when `ra_idx` is 0; otherwise it is `ra_val`.
- R2: With `indexed`=0 the effective address is base plus the sign-extended 16-bit `imm`; with `indexed`=1 it is base plus `rb_val`.
- R3: With `ds_form`=1 (displacement only) the offset is `{imm[15:2],2'b00}` sign-extended, so `imm[1:0]` are ignored.
- R4: The `size` code gives the byte count: 0 → 1, 1 → 2, 2 → 4, 3 → 8, reported on `mem_nbytes`. The stored field is the low 8/16/32/64 bits of `rs_val`. `mem_be` has exactly those bits set, contiguous and starting at lane `ea[2:0]`.
- R5: Without byte reversal the most significant byte of the field goes to lane `ea[2:0]`, and less significant bytes go to the following lanes. Lanes that are not enabled carry zero.
- R6: With `byte_rev`=1 the least significant byte of the field goes to lane `ea[2:0]`, and the byte order on the lanes is reversed for 2, 4 and 8 byte stores.
- R7: In an update form with `ra_idx`≠0, `wb_valid` pulses for one cycle, with `wb_idx`=`ra_idx` and `wb_data`=EA. The pulse comes in the cycle after `mem_valid` and `mem_ready` are both high. The base of an update form is always `ra_val`. Non-update stores never pulse `wb_valid`.
- R8: A store is an invalid form when it is an update form with `ra_idx`=0, or when it has `byte_rev`=1 with `indexed`=0. It gives a one-cycle `bad_form` pulse in the cycle after acceptance, with no `mem_valid` and no `wb_valid`.
- R9: A legal store with `ea[2:0]` + byte count > 8 gives a one-cycle `misalign` pulse in the cycle after acceptance, with no write and no writeback.
- R10: A request appears on `mem_valid` in the cycle after acceptance. Address, data, enables and count stay stable until `mem_ready` is high. `in_ready` is low while a request is pending.
- R11: While `rst` is high and after it is released, `mem_valid`, `wb_valid`, `bad_form` and `misalign` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded store present |
| in_ready | output | 1 | Block can accept a store |
| size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| indexed | input | 1 | Offset from `rb_val` instead of immediate |
| ds_form | input | 1 | Immediate is word-scaled (low two bits forced to zero) |
| update | input | 1 | Write EA back to the base register |
| byte_rev | input | 1 | Byte-reversed store |
| imm | input | 16 | Displacement field |
| ra_idx | input | 5 | Base register number |
| ra_val | input | 64 | Base register contents |
| rb_val | input | 64 | Index register contents |
| rs_val | input | 64 | Source register contents |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Effective address |
| mem_nbytes | output | 4 | Number of bytes written |
| mem_be | output | 8 | Byte-lane enables |
| mem_wdata | output | 64 | Lane-aligned write data |
| wb_valid | output | 1 | Base register writeback pulse |
| wb_idx | output | 5 | Writeback register number |
| wb_data | output | 64 | Writeback value (EA) |
| bad_form | output | 1 | Invalid-form pulse |
| misalign | output | 1 | Boundary-crossing pulse |

## Verification
The request fields, `bad_form` and `misalign` are all due one clock edge after the edge that accepts the store. The writeback pulse is due exactly one edge after the edge where the memory handshake completes. The bench drives and releases inputs at falling edges. It checks the request and the flags at the first falling edge after acceptance, while `mem_ready` is high, and checks the writeback at the next falling edge. The back-pressure scenario holds `mem_ready` low for several cycles and checks at each falling edge that the request stays unchanged and that no writeback appears early.

// File: rtl/fxst_pkg.sv
package fxst_pkg;
  localparam int XLEN  = 64;
  localparam int IMMW  = 16;
  localparam int IDXW  = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } st_size_e;
endpackage

// File: rtl/fxst_ea_calc.sv
module fxst_ea_calc #(
  parameter int XW = 64,
  parameter int IW = 16,
  parameter int RW = 5
) (
  input  logic [RW-1:0] ra_idx,
  input  logic [XW-1:0] ra_val,
  input  logic [XW-1:0] rb_val,
  input  logic [IW-1:0] imm,
  input  logic          indexed,
  input  logic          ds_form,
  input  logic          update,
  input  logic          byte_rev,
  output logic [XW-1:0] ea,
  output logic          illegal
);
  localparam int EXTW = XW - IW;

  logic          ra_is_zero;
  logic [XW-1:0] base;
  logic [IW-1:0] imm_scaled;
  logic [XW-1:0] disp;
  logic [XW-1:0] offset;

  assign ra_is_zero = (ra_idx == '0);

  // update forms always take the register contents
  assign base = (ra_is_zero && !update) ? '0 : ra_val;

  assign imm_scaled = ds_form ? {imm[IW-1:2], 2'b00} : imm;
  assign disp       = {{EXTW{imm_scaled[IW-1]}}, imm_scaled};
  assign offset     = indexed ? rb_val : disp;
  assign ea         = base + offset;

  assign illegal = (update && ra_is_zero) || (byte_rev && !indexed);
endmodule

// File: rtl/fxst_lane_fmt.sv
module fxst_lane_fmt #(
  parameter int DW = 64
) (
  input  logic [1:0]                size,
  input  logic                      byte_rev,
  input  logic [$clog2(DW/8)-1:0]   lane_off,
  input  logic [DW-1:0]             rs_val,
  output logic [DW-1:0]             lanes,
  output logic [DW/8-1:0]           enables,
  output logic [$clog2(DW/8):0]     nbytes,
  output logic                      crosses
);
  localparam int NB = DW / 8;
  localparam int OW = $clog2(NB);
  localparam int CW = OW + 1;

  logic [CW-1:0] span_end;

  assign nbytes   = CW'(1) << size;
  assign span_end = CW'(lane_off) + nbytes;
  assign crosses  = span_end > CW'(NB);

  for (genvar k = 0; k < NB; k++) begin : g_lane
    int rel;
    int src;
    always_comb begin
      rel = k - int'(lane_off);
      src = 0;
      enables[k]     = 1'b0;
      lanes[8*k +: 8] = 8'h00;
      if (rel >= 0 && rel < int'(nbytes)) begin
        src = byte_rev ? rel : (int'(nbytes) - 1 - rel);
        enables[k]      = 1'b1;
        lanes[8*k +: 8] = rs_val[8*src +: 8];
      end
    end
  end
endmodule

// File: rtl/fxst_issue.sv
module fxst_issue
  import fxst_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int IW = IMMW,
  parameter int RW = IDXW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              size,
  input  logic                    indexed,
  input  logic                    ds_form,
  input  logic                    update,
  input  logic                    byte_rev,
  input  logic [IW-1:0]           imm,
  input  logic [RW-1:0]           ra_idx,
  input  logic [DW-1:0]           ra_val,
  input  logic [DW-1:0]           rb_val,
  input  logic [DW-1:0]           rs_val,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [DW-1:0]           mem_addr,
  output logic [$clog2(DW/8):0]   mem_nbytes,
  output logic [DW/8-1:0]         mem_be,
  output logic [DW-1:0]           mem_wdata,
  output logic                    wb_valid,
  output logic [RW-1:0]           wb_idx,
  output logic [DW-1:0]           wb_data,
  output logic                    bad_form,
  output logic                    misalign
);
  localparam int NB = DW / 8;
  localparam int OW = $clog2(NB);
  localparam int CW = OW + 1;

  logic [DW-1:0] ea_c;
  logic          illegal_c;
  logic [DW-1:0] lanes_c;
  logic [NB-1:0] be_c;
  logic [CW-1:0] nbytes_c;
  logic          cross_c;
  logic          accept;
  logic          pend_upd;

  fxst_ea_calc #(.XW(DW), .IW(IW), .RW(RW)) u_ea (
    .ra_idx   (ra_idx),
    .ra_val   (ra_val),
    .rb_val   (rb_val),
    .imm      (imm),
    .indexed  (indexed),
    .ds_form  (ds_form),
    .update   (update),
    .byte_rev (byte_rev),
    .ea       (ea_c),
    .illegal  (illegal_c)
  );

  fxst_lane_fmt #(.DW(DW)) u_fmt (
    .size     (size),
    .byte_rev (byte_rev),
    .lane_off (ea_c[OW-1:0]),
    .rs_val   (rs_val),
    .lanes    (lanes_c),
    .enables  (be_c),
    .nbytes   (nbytes_c),
    .crosses  (cross_c)
  );

  assign in_ready = !mem_valid;
  assign accept   = in_valid && in_ready;

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      wb_valid  <= 1'b0;
      bad_form  <= 1'b0;
      misalign  <= 1'b0;
      pend_upd  <= 1'b0;
    end else begin
      wb_valid <= 1'b0;
      bad_form <= 1'b0;
      misalign <= 1'b0;
      if (mem_valid && mem_ready) begin
        mem_valid <= 1'b0;
        wb_valid  <= pend_upd;
      end
      if (accept) begin
        if (illegal_c) begin
          bad_form <= 1'b1;
        end else if (cross_c) begin
          misalign <= 1'b1;
        end else begin
          mem_valid <= 1'b1;
          pend_upd  <= update;
        end
      end
    end
  end

  // request and writeback payload, no reset needed
  always_ff @(posedge clk) begin
    if (accept && !illegal_c && !cross_c) begin
      mem_addr   <= ea_c;
      mem_nbytes <= nbytes_c;
      mem_be     <= be_c;
      mem_wdata  <= lanes_c;
      wb_idx     <= ra_idx;
      wb_data    <= ea_c;
    end
  end

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
      $stable(mem_wdata) && $stable(mem_be) && $stable(mem_nbytes)));

  // R7
  wb_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(mem_valid && mem_ready));

  // R7
  wb_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_idx != '0));

  // R4
  be_count_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ($countones(mem_be) == int'(mem_nbytes)));

  // R8
  bad_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    bad_form |-> (!mem_valid && !wb_valid));

  // R9
  mis_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (!mem_valid && !bad_form));
endmodule

// File: tb/tb_fxst_issue.sv
module tb_fxst_issue;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [1:0]  size;
  logic        indexed, ds_form, update, byte_rev;
  logic [15:0] imm;
  logic [4:0]  ra_idx;
  logic [63:0] ra_val, rb_val, rs_val;
  logic        mem_valid, mem_ready;
  logic [63:0] mem_addr;
  logic [3:0]  mem_nbytes;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic        bad_form, misalign;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fxst_issue dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .size(size), .indexed(indexed), .ds_form(ds_form), .update(update),
    .byte_rev(byte_rev), .imm(imm), .ra_idx(ra_idx), .ra_val(ra_val),
    .rb_val(rb_val), .rs_val(rs_val), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_nbytes(mem_nbytes),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data), .bad_form(bad_form),
    .misalign(misalign)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent model of the expected request.
  task automatic model(input logic [1:0] sz, input logic ix, input logic ds,
                       input logic up, input logic rv, input logic [15:0] im,
                       input logic [4:0] ri, input logic [63:0] ra,
                       input logic [63:0] rb, input logic [63:0] rs,
                       output logic [63:0] ea, output logic inv,
                       output logic crs, output logic [7:0] be,
                       output logic [63:0] wd, output logic [3:0] nb);
    logic [63:0] b, off;
    logic [15:0] e;
    int o, n;
    b   = (ri == 0 && !up) ? 64'd0 : ra;
    e   = ds ? (im & 16'hFFFC) : im;
    off = ix ? rb : {{48{e[15]}}, e};
    ea  = b + off;
    inv = (up && ri == 0) || (rv && !ix);
    n   = 1 << sz;
    nb  = 4'(n);
    o   = int'(ea[2:0]);
    crs = (o + n) > 8;
    be  = '0;
    wd  = '0;
    for (int i = 0; i < n; i++) begin
      if (o + i < 8) begin
        be[o+i] = 1'b1;
        wd[8*(o+i) +: 8] = rv ? rs[8*i +: 8] : rs[8*(n-1-i) +: 8];
      end
    end
  endtask

  task automatic drive(input logic [1:0] sz, input logic ix, input logic ds,
                       input logic up, input logic rv, input logic [15:0] im,
                       input logic [4:0] ri, input logic [63:0] ra,
                       input logic [63:0] rb, input logic [63:0] rs);
    size = sz; indexed = ix; ds_form = ds; update = up; byte_rev = rv;
    imm = im; ra_idx = ri; ra_val = ra; rb_val = rb; rs_val = rs;
    in_valid = 1'b1;
  endtask

  // One store with mem_ready high: checks the request, then the writeback.
  task automatic run_store(string req, input logic [1:0] sz, input logic ix,
                           input logic ds, input logic up, input logic rv,
                           input logic [15:0] im, input logic [4:0] ri,
                           input logic [63:0] ra, input logic [63:0] rb,
                           input logic [63:0] rs);
    logic [63:0] ea, wd;
    logic inv, crs;
    logic [7:0] be;
    logic [3:0] nb;
    model(sz, ix, ds, up, rv, im, ri, ra, rb, rs, ea, inv, crs, be, wd, nb);
    @(negedge clk);
    mem_ready = 1'b1;
    drive(sz, ix, ds, up, rv, im, ri, ra, rb, rs);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "bad_form", 64'(bad_form), 64'(inv));
    chk(req, "misalign", 64'(misalign), 64'(!inv && crs));
    chk(req, "mem_valid", 64'(mem_valid), 64'(!inv && !crs));
    if (!inv && !crs) begin
      chk(req, "addr", mem_addr, ea);
      chk(req, "be", 64'(mem_be), 64'(be));
      chk(req, "wdata", mem_wdata, wd);
      chk(req, "nbytes", 64'(mem_nbytes), 64'(nb));
    end
    @(negedge clk);
    chk(req, "wb_valid", 64'(wb_valid), 64'(!inv && !crs && up));
    if (!inv && !crs && up) begin
      chk(req, "wb_idx", 64'(wb_idx), 64'(ri));
      chk(req, "wb_data", wb_data, ea);
    end
    chk(req, "mem_valid_clear", 64'(mem_valid), 64'(0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R11
    chk("R11", "mem_valid", 64'(mem_valid), 64'(0));
    chk("R11", "wb_valid", 64'(wb_valid), 64'(0));
    chk("R11", "bad_form", 64'(bad_form), 64'(0));
    chk("R11", "misalign", 64'(misalign), 64'(0));
    chk("R11", "in_ready", 64'(in_ready), 64'(1));
  endtask

  task automatic t_base_zero();
    // R1: ra_idx 0 ignores ra_val; ra_idx 7 uses it
    run_store("R1", 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0010, 5'd0,
              64'hDEAD_0000_0000_0000, 64'd0, 64'h0102_0304_0506_0708);
    run_store("R1", 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 5'd7,
              64'h0000_0000_0000_1000, 64'h24, 64'hAAAA_BBBB_1122_3344);
  endtask

  task automatic t_forms();
    // R2: negative displacement, indexed with large index
    run_store("R2", 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFF0, 5'd3,
              64'h0000_0000_0000_2006, 64'd0, 64'h0000_0000_0000_BEEF);
    run_store("R2", 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h1234, 5'd3,
              64'h100, 64'hFFFF_FFFF_FFFF_FF05, 64'h77);
    // R3: low imm bits ignored, negative scaled offset
    run_store("R3", 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFB, 5'd4,
              64'h0000_0000_0000_4000, 64'd0, 64'h1122_3344_5566_7788);
    run_store("R3", 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0013, 5'd4,
              64'h0000_0000_0000_4000, 64'd0, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_sizes();
    // R4 R5: each size at several lane offsets
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 8; o += (1 << s)) begin
        run_store("R4", 2'(s), 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 5'd1,
                  64'h8000, 64'(o), 64'hF1E2_D3C4_B5A6_9788);
      end
    end
    run_store("R5", 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 5'd1,
              64'h8000, 64'd4, 64'h0000_0000_CAFE_F00D);
  endtask

  task automatic t_reverse();
    // R6
    run_store("R6", 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0, 5'd2,
              64'h10, 64'd6, 64'h0000_0000_0000_ABCD);
    run_store("R6", 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0, 5'd2,
              64'h10, 64'd0, 64'h0000_0000_0102_0304);
    run_store("R6", 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0, 5'd0,
              64'h10, 64'h88, 64'h0102_0304_0506_0708);
  endtask

  task automatic t_update();
    // R7: displacement and indexed update forms, plus non-update no pulse
    run_store("R7", 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFC, 5'd9,
              64'h0000_0000_0000_3000, 64'd0, 64'h5555_6666);
    run_store("R7", 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, 5'd31,
              64'h0000_0001_0000_0000, 64'h40, 64'h1);
    run_store("R7", 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 5'd31,
              64'h0000_0001_0000_0000, 64'h40, 64'h1);
  endtask

  task automatic t_invalid();
    // R8
    run_store("R8", 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 16'h8, 5'd0,
              64'h100, 64'd0, 64'h9);
    run_store("R8", 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 16'h8, 5'd5,
              64'h100, 64'd0, 64'h9);
  endtask

  task automatic t_misalign();
    // R9
    run_store("R9", 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, 5'd6,
              64'h200, 64'd6, 64'h1234_5678);
    run_store("R9", 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 5'd6,
              64'h200, 64'd0, 64'h1);
  endtask

  task automatic t_backpressure();
    logic [63:0] ea, wd;
    logic inv, crs;
    logic [7:0] be;
    logic [3:0] nb;
    // R10
    model(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, 5'd12, 64'h5000, 64'h2,
          64'h0000_0000_0000_4321, ea, inv, crs, be, wd, nb);
    @(negedge clk);
    mem_ready = 1'b0;
    drive(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, 5'd12, 64'h5000, 64'h2,
          64'h0000_0000_0000_4321);
    @(negedge clk);
    in_valid = 1'b0;
    ra_val = 64'hFFFF; rb_val = 64'h7; rs_val = '1;
    for (int c = 0; c < 4; c++) begin
      chk("R10", "mem_valid_held", 64'(mem_valid), 64'(1));
      chk("R10", "in_ready_low", 64'(in_ready), 64'(0));
      chk("R10", "addr_held", mem_addr, ea);
      chk("R10", "wdata_held", mem_wdata, wd);
      chk("R7", "no_early_wb", 64'(wb_valid), 64'(0));
      @(negedge clk);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    chk("R7", "wb_after_ready", 64'(wb_valid), 64'(1));
    chk("R7", "wb_data", wb_data, ea);
    chk("R10", "in_ready_back", 64'(in_ready), 64'(1));
  endtask

  task automatic t_random();
    for (int k = 0; k < 150; k++) begin
      logic ix;
      ix = 1'($urandom);
      run_store("R2", 2'($urandom), ix, ix ? 1'b0 : 1'($urandom),
                1'($urandom), ix ? 1'($urandom) : 1'b0, 16'($urandom),
                5'($urandom % 4), {32'($urandom), 32'($urandom)},
                64'($signed(16'($urandom))), {32'($urandom), 32'($urandom)});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0; mem_ready = 1'b1;
    size = '0; indexed = 1'b0; ds_form = 1'b0; update = 1'b0; byte_rev = 1'b0;
    imm = '0; ra_idx = '0; ra_val = '0; rb_val = '0; rs_val = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_base_zero();
    t_forms();
    t_sizes();
    t_reverse();
    t_update();
    t_invalid();
    t_misalign();
    t_backpressure();
    t_random();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule